// File: doc/BRIEF.md
# Immediate Branch Execution Unit

This unit executes unconditional branches whose target comes from an immediate field, in a simple 32-bit in-order pipeline that issues at most one instruction per cycle. Each branch carries three independent flags. The link flag saves the branch PC to a destination register. The absolute flag chooses between the extended immediate itself and the branch PC plus that immediate as the target. The delay flag lets one following instruction execute before the target. An immediate-prefix instruction may come just before the branch and supply the upper 16 bits of the target operand.

A small state machine has three states: `ST_IDLE`, `ST_SLOT` and `ST_FLUSH`. It decides whether the next issued instruction is a delay slot or must be discarded while fetch is redirected. Its transitions are:
- `ST_IDLE -> ST_SLOT` on an accepted delayed branch.
- `ST_IDLE -> ST_FLUSH` on an accepted non-delayed branch.
- `ST_SLOT -> ST_IDLE` once the slot instruction is accepted. It stays in `ST_SLOT` while nothing issues.
- `ST_FLUSH -> ST_IDLE` after `LAT_NODELAY-1` bubble cycles.

Interrupt and break requests are held while a branch is in flight. Illegal slot contents and the link-without-delay encoding raise error flags. One special absolute, linked, delayed target starts a user-vector exception when the MMU parameter is set. That exception saves the user and virtual mode bits and then clears them.

Top module: `imm_branch_unit`

## Requirements
- R1: An accepted branch with the link flag drives `wb_en`=1, `wb_rd`=`ins_rd` and `wb_data`=`ins_pc` in its issue cycle. An unlinked branch leaves `wb_en`=0.
- R2: In the issue cycle of an accepted branch, `redirect_valid`=1. `redirect_pc` equals the extended immediate when `ins_abs`=1, and equals `ins_pc` plus the extended immediate, modulo 2^32, when `ins_abs`=0.
- R3: Without a pending prefix, the 16-bit immediate is sign-extended. With a pending prefix, the prefix's 16 bits form bits 31:16 and the branch immediate forms bits 15:0.
- R4: A prefix (`ins_class`=1) accepted in `ST_IDLE` is pending for exactly one following accepted instruction. Reset also clears it.
- R5: After a delayed branch, `slot_active`=1 and `stall`=0 until one instruction is accepted. The cycle after that, the unit is idle.
- R6: After a non-delayed branch, `stall`=1 for the next 2 cycles (`LAT_NODELAY`=3 total), with `squash`=1 only in the first of them. Instructions offered while `stall`=1 are ignored.
- R7: If `MMU_EN`≠0, a branch with link, absolute and delay set and with target `BASE_VEC`+8 drives `msr_we`=1, `msr_ums_next`=`msr_um`, `msr_vms_next`=`msr_vm`, and `msr_um_next`=`msr_vm_next`=0. If `MMU_EN`=0, `msr_we` stays 0.
- R8: An instruction accepted in `ST_SLOT` whose class is prefix (1), branch (2) or break (3) raises `illegal_slot`, and a branch there is not executed. Class 0 (other) is legal.
- R9: `irq_take` and `brk_take` follow `irq_req` and `brk_req` only in `ST_IDLE` and in cycles where no branch is accepted. In any other cycle the requests are held.
- R10: A branch with link set and delay clear raises `illegal_insn`, with no redirect and no write-back, and the unit stays idle.
- R11: After reset the unit is idle: `stall`, `slot_active`, `squash`, `redirect_valid`, `wb_en` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | An instruction is offered this cycle |
| ins_class | input | 2 | 0 other, 1 prefix, 2 branch, 3 break |
| ins_link | input | 1 | Branch link flag |
| ins_abs | input | 1 | Branch absolute flag |
| ins_delay | input | 1 | Branch delay flag |
| ins_imm | input | 16 | Immediate field (also the prefix payload) |
| ins_rd | input | 5 | Destination register index |
| ins_pc | input | 32 | PC of the offered instruction |
| irq_req | input | 1 | Interrupt request |
| brk_req | input | 1 | External break request |
| msr_um | input | 1 | Current user-mode bit |
| msr_vm | input | 1 | Current virtual-mode bit |
| stall | output | 1 | Fetch redirect bubble, issue blocked |
| slot_active | output | 1 | Next accepted instruction is a delay slot |
| squash | output | 1 | Discard the fetched successor |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | 32 | Branch target |
| wb_en | output | 1 | Link write-back enable |
| wb_rd | output | 5 | Link write-back register |
| wb_data | output | 32 | Link value |
| illegal_slot | output | 1 | Forbidden instruction in delay slot |
| illegal_insn | output | 1 | Link-without-delay encoding |
| irq_take | output | 1 | Interrupt accepted |
| brk_take | output | 1 | Break accepted |
| msr_we | output | 1 | Status update strobe |
| msr_um_next | output | 1 | New user-mode bit |
| msr_vm_next | output | 1 | New virtual-mode bit |
| msr_ums_next | output | 1 | Saved user-mode bit |
| msr_vms_next | output | 1 | Saved virtual-mode bit |

## Verification
Two functions can coincide in one cycle: interrupt acceptance and branch handling. The bench holds `irq_req` and `brk_req` high across a delayed branch, including a slot cycle where nothing issues, and again across a non-delayed flush. It expects `irq_take` to stay low in the issue cycle, throughout `ST_SLOT` or `ST_FLUSH`, and in the cycle the slot instruction is accepted. It expects `irq_take` to rise in the first idle cycle after that. A second case puts a prefix and a branch into the delay slot. There the bench expects `illegal_slot` with no redirect, and expects the prefix not to affect the next branch's target.

// File: rtl/ibu_pkg.sv
package ibu_pkg;
    typedef enum logic [1:0] {
        CL_OTHER  = 2'd0,
        CL_PREFIX = 2'd1,
        CL_BRANCH = 2'd2,
        CL_BREAK  = 2'd3
    } ins_class_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT  = 2'd1,
        ST_FLUSH = 2'd2
    } br_state_t;
endpackage

// File: rtl/ibu_prefix.sv
module ibu_prefix #(
    parameter int HI_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            consume,
    input  logic [HI_W-1:0] hi_in,
    output logic            valid,
    output logic [HI_W-1:0] hi
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            hi    <= '0;
        end else if (load) begin
            valid <= 1'b1;
            hi    <= hi_in;
        end else if (consume) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ibu_target.sv
module ibu_target #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0]       pc,
    input  logic [IMM_W-1:0]        imm,
    input  logic                    pfx_valid,
    input  logic [ADDR_W-IMM_W-1:0] pfx_hi,
    input  logic                    absolute,
    output logic [ADDR_W-1:0]       target
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] operand;

    always_comb begin
        if (pfx_valid)
            operand = {pfx_hi, imm};
        else
            operand = {{EXT_W{imm[IMM_W-1]}}, imm};
        target = absolute ? operand : (pc + operand);
    end
endmodule

// File: rtl/ibu_fsm.sv
module ibu_fsm
    import ibu_pkg::*;
#(
    parameter int LAT_NODELAY = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_delay,
    input  logic      go_flush,
    input  logic      slot_done,
    output br_state_t state,
    output logic      slot_active,
    output logic      stall,
    output logic      squash
);
    localparam int BUBBLES = LAT_NODELAY - 1;
    localparam int CW      = $clog2(BUBBLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUBBLES - 1);

    br_state_t     nxt;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && go_flush)
                cnt <= LOAD;
            else if (state == ST_FLUSH && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go_delay)      nxt = ST_SLOT;
                else if (go_flush) nxt = ST_FLUSH;
            end
            ST_SLOT:  if (slot_done) nxt = ST_IDLE;
            ST_FLUSH: if (cnt == '0) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        slot_active = (state == ST_SLOT);
        stall       = (state == ST_FLUSH);
        squash      = (state == ST_FLUSH) && (cnt == LOAD);
    end
endmodule

// File: rtl/imm_branch_unit.sv
module imm_branch_unit
    import ibu_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              IMM_W       = 16,
    parameter int              RIDX_W      = 5,
    parameter int              LAT_NODELAY = 3,
    parameter int              MMU_EN      = 1,
    parameter logic [ADDR_W-1:0] BASE_VEC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [1:0]        ins_class,
    input  logic              ins_link,
    input  logic              ins_abs,
    input  logic              ins_delay,
    input  logic [IMM_W-1:0]  ins_imm,
    input  logic [RIDX_W-1:0] ins_rd,
    input  logic [ADDR_W-1:0] ins_pc,
    input  logic              irq_req,
    input  logic              brk_req,
    input  logic              msr_um,
    input  logic              msr_vm,
    output logic              stall,
    output logic              slot_active,
    output logic              squash,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_rd,
    output logic [ADDR_W-1:0] wb_data,
    output logic              illegal_slot,
    output logic              illegal_insn,
    output logic              irq_take,
    output logic              brk_take,
    output logic              msr_we,
    output logic              msr_um_next,
    output logic              msr_vm_next,
    output logic              msr_ums_next,
    output logic              msr_vms_next
);
    localparam int HI_W = ADDR_W - IMM_W;
    localparam logic [ADDR_W-1:0] UVEC = BASE_VEC + ADDR_W'(8);

    ins_class_t        cls;
    br_state_t         st;
    logic              acc, in_idle, is_br, go, bad_combo;
    logic              pfx_load, slot_done, pfx_valid, uvec_hit;
    logic [HI_W-1:0]   pfx_hi;
    logic [ADDR_W-1:0] target;

    assign cls       = ins_class_t'(ins_class);
    assign in_idle   = (st == ST_IDLE);
    assign acc       = ins_valid && (st != ST_FLUSH);
    assign is_br     = acc && in_idle && (cls == CL_BRANCH);
    assign bad_combo = ins_link && !ins_delay;
    assign go        = is_br && !bad_combo;
    assign pfx_load  = acc && in_idle && (cls == CL_PREFIX);
    assign slot_done = acc && (st == ST_SLOT);

    ibu_prefix #(.HI_W(HI_W)) u_prefix (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pfx_load),
        .consume (acc),
        .hi_in   (ins_imm[HI_W-1:0]),
        .valid   (pfx_valid),
        .hi      (pfx_hi)
    );

    ibu_target #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_target (
        .pc        (ins_pc),
        .imm       (ins_imm),
        .pfx_valid (pfx_valid),
        .pfx_hi    (pfx_hi),
        .absolute  (ins_abs),
        .target    (target)
    );

    ibu_fsm #(.LAT_NODELAY(LAT_NODELAY)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_delay    (go && ins_delay),
        .go_flush    (go && !ins_delay),
        .slot_done   (slot_done),
        .state       (st),
        .slot_active (slot_active),
        .stall       (stall),
        .squash      (squash)
    );

    generate
        if (MMU_EN != 0) begin : g_uvec
            assign uvec_hit = go && ins_link && ins_abs && ins_delay && (target == UVEC);
        end else begin : g_no_uvec
            assign uvec_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        redirect_valid = go;
        redirect_pc    = target;
        wb_en          = go && ins_link;
        wb_rd          = ins_rd;
        wb_data        = ins_pc;
        illegal_insn   = is_br && bad_combo;
        illegal_slot   = slot_done && (cls != CL_OTHER);
        irq_take       = irq_req && in_idle && !is_br;
        brk_take       = brk_req && in_idle && !is_br;
        msr_we         = uvec_hit;
        msr_um_next    = uvec_hit ? 1'b0 : msr_um;
        msr_vm_next    = uvec_hit ? 1'b0 : msr_vm;
        msr_ums_next   = msr_um;
        msr_vms_next   = msr_vm;
    end
endmodule

// File: rtl/ibu_checker.sv
module ibu_checker #(
    parameter int LAT_NODELAY = 3
) (
    input logic clk,
    input logic rst_n,
    input logic ins_link,
    input logic ins_delay,
    input logic stall,
    input logic slot_active,
    input logic squash,
    input logic redirect_valid,
    input logic wb_en,
    input logic illegal_slot,
    input logic illegal_insn,
    input logic irq_take,
    input logic brk_take,
    input logic msr_we,
    input logic msr_um_next,
    input logic msr_vm_next
);
    logic [15:0] stall_run;

    always_ff @(posedge clk) begin
        if (!rst_n)     stall_run <= '0;
        else if (stall) stall_run <= stall_run + 1'b1;
        else            stall_run <= '0;
    end

    p_link_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (redirect_valid && ins_link));

    p_slot_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && ins_delay) |=> (slot_active && !stall));

    p_flush_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !ins_delay) |=> (stall && squash));

    p_flush_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= 16'(LAT_NODELAY - 1));

    p_excl_states_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slot_active, stall}));

    p_uvec_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we |-> (!msr_um_next && !msr_vm_next && redirect_valid));

    p_slot_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_slot |-> (slot_active && !redirect_valid));

    p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_active || stall) |-> (!irq_take && !brk_take));

    p_bad_combo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_insn |-> (!redirect_valid && !wb_en));
endmodule

bind imm_branch_unit ibu_checker #(.LAT_NODELAY(LAT_NODELAY)) u_ibu_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_link       (ins_link),
    .ins_delay      (ins_delay),
    .stall          (stall),
    .slot_active    (slot_active),
    .squash         (squash),
    .redirect_valid (redirect_valid),
    .wb_en          (wb_en),
    .illegal_slot   (illegal_slot),
    .illegal_insn   (illegal_insn),
    .irq_take       (irq_take),
    .brk_take       (brk_take),
    .msr_we         (msr_we),
    .msr_um_next    (msr_um_next),
    .msr_vm_next    (msr_vm_next)
);

// File: tb/tb_imm_branch_unit.sv
module tb_imm_branch_unit;
    logic clk = 1'b0;
    logic rst_n;
    logic ins_valid, ins_link, ins_abs, ins_delay, irq_req, brk_req, msr_um, msr_vm;
    logic [1:0]  ins_class;
    logic [15:0] ins_imm;
    logic [4:0]  ins_rd;
    logic [31:0] ins_pc;

    logic stall, slot_active, squash, redirect_valid, wb_en, illegal_slot, illegal_insn;
    logic irq_take, brk_take, msr_we, msr_um_next, msr_vm_next, msr_ums_next, msr_vms_next;
    logic [31:0] redirect_pc, wb_data;
    logic [4:0]  wb_rd;

    logic n_stall, n_slot, n_squash, n_rv, n_wb_en, n_ils, n_ili, n_irq, n_brk;
    logic n_we, n_um, n_vm, n_ums, n_vms;
    logic [31:0] n_rpc, n_wbd;
    logic [4:0]  n_wrd;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    imm_branch_unit #(.MMU_EN(1)) dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
        .ins_link(ins_link), .ins_abs(ins_abs), .ins_delay(ins_delay), .ins_imm(ins_imm),
        .ins_rd(ins_rd), .ins_pc(ins_pc), .irq_req(irq_req), .brk_req(brk_req),
        .msr_um(msr_um), .msr_vm(msr_vm), .stall(stall), .slot_active(slot_active),
        .squash(squash), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data), .illegal_slot(illegal_slot),
        .illegal_insn(illegal_insn), .irq_take(irq_take), .brk_take(brk_take),
        .msr_we(msr_we), .msr_um_next(msr_um_next), .msr_vm_next(msr_vm_next),
        .msr_ums_next(msr_ums_next), .msr_vms_next(msr_vms_next)
    );

    imm_branch_unit #(.MMU_EN(0)) dut_nommu (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
        .ins_link(ins_link), .ins_abs(ins_abs), .ins_delay(ins_delay), .ins_imm(ins_imm),
        .ins_rd(ins_rd), .ins_pc(ins_pc), .irq_req(irq_req), .brk_req(brk_req),
        .msr_um(msr_um), .msr_vm(msr_vm), .stall(n_stall), .slot_active(n_slot),
        .squash(n_squash), .redirect_valid(n_rv), .redirect_pc(n_rpc),
        .wb_en(n_wb_en), .wb_rd(n_wrd), .wb_data(n_wbd), .illegal_slot(n_ils),
        .illegal_insn(n_ili), .irq_take(n_irq), .brk_take(n_brk),
        .msr_we(n_we), .msr_um_next(n_um), .msr_vm_next(n_vm),
        .msr_ums_next(n_ums), .msr_vms_next(n_vms)
    );

    typedef struct packed {
        logic        l;
        logic        a;
        logic        d;
        logic [15:0] imm;
        logic [31:0] pc;
        logic [31:0] tgt;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h0010, 32'h0000_1000, 32'h0000_1010},
        '{1'b0, 1'b0, 1'b1, 16'hFFF0, 32'h0000_1000, 32'h0000_0FF0},
        '{1'b0, 1'b1, 1'b0, 16'h8000, 32'h1234_5678, 32'hFFFF_8000},
        '{1'b0, 1'b1, 1'b1, 16'h7FFC, 32'h0000_0000, 32'h0000_7FFC},
        '{1'b1, 1'b0, 1'b1, 16'hFFFC, 32'h0000_0002, 32'hFFFF_FFFE},
        '{1'b1, 1'b1, 1'b1, 16'h0100, 32'hABCD_0000, 32'h0000_0100},
        '{1'b0, 1'b0, 1'b0, 16'h0004, 32'hFFFF_FFFE, 32'h0000_0002}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic adv();
        @(posedge clk);
        #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    task automatic quiet();
        ins_valid = 1'b0; ins_class = 2'd0; ins_link = 1'b0; ins_abs = 1'b0;
        ins_delay = 1'b0; ins_imm = '0; ins_rd = '0; ins_pc = '0;
    endtask

    task automatic offer(input logic [1:0] c, input logic l, input logic a, input logic d,
                         input logic [15:0] imm, input logic [31:0] pc);
        ins_valid = 1'b1; ins_class = c; ins_link = l; ins_abs = a; ins_delay = d;
        ins_imm = imm; ins_pc = pc; ins_rd = 5'd15;
    endtask

    // finish a branch already checked in its issue cycle (now at posedge+1)
    task automatic finish_branch(input logic d, input string tag);
        if (d) begin
            offer(2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0);
            mid();
            check({"R5 slot_active ", tag}, 32'(slot_active), 32'd1);
            check({"R5 no stall in slot ", tag}, 32'(stall), 32'd0);
            check({"R8 legal slot ", tag}, 32'(illegal_slot), 32'd0);
            adv();
            quiet();
            mid();
            check({"R5 idle after slot ", tag}, 32'({slot_active, stall}), 32'd0);
            adv();
        end else begin
            mid();
            check({"R6 flush cycle 1 ", tag}, 32'({stall, squash}), 32'b11);
            adv();
            mid();
            check({"R6 flush cycle 2 ", tag}, 32'({stall, squash}), 32'b10);
            adv();
            mid();
            check({"R6 idle after flush ", tag}, 32'(stall), 32'd0);
            adv();
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        quiet();
        irq_req = 1'b0; brk_req = 1'b0; msr_um = 1'b0; msr_vm = 1'b0;
        rst_n = 1'b0;
        repeat (3) adv();
        mid();
        check("R11 reset outputs", 32'({stall, slot_active, squash, redirect_valid,
                                        wb_en, illegal_slot, illegal_insn}), 32'd0);
        rst_n = 1'b1;
        adv();

        // table walk: every legal flag combination, wraps both ways
        for (int i = 0; i < NV; i++) begin
            offer(2'd2, VECS[i].l, VECS[i].a, VECS[i].d, VECS[i].imm, VECS[i].pc);
            mid();
            check($sformatf("R2 redirect_valid vec%0d", i), 32'(redirect_valid), 32'd1);
            check($sformatf("R2 R3 target vec%0d", i), redirect_pc, VECS[i].tgt);
            check($sformatf("R1 wb_en vec%0d", i), 32'(wb_en), 32'(VECS[i].l));
            if (VECS[i].l) begin
                check($sformatf("R1 wb_data vec%0d", i), wb_data, VECS[i].pc);
                check($sformatf("R1 wb_rd vec%0d", i), 32'(wb_rd), 32'd15);
            end
            adv();
            quiet();
            finish_branch(VECS[i].d, $sformatf("vec%0d", i));
        end

        // R3/R4: prefix supplies upper half, absolute
        offer(2'd1, 1'b0, 1'b0, 1'b0, 16'h1234, 32'h40);
        adv();
        offer(2'd2, 1'b0, 1'b1, 1'b1, 16'h5678, 32'h44);
        mid();
        check("R3 prefixed absolute target", redirect_pc, 32'h1234_5678);
        adv();
        quiet();
        finish_branch(1'b1, "pfx abs");

        // R3: prefix with relative (no sign extension of low half)
        offer(2'd1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 32'hFC);
        adv();
        offer(2'd2, 1'b0, 1'b0, 1'b0, 16'h8000, 32'h100);
        mid();
        check("R3 prefixed relative target", redirect_pc, 32'hFFFF_8100);
        adv();
        quiet();
        finish_branch(1'b0, "pfx rel");

        // R4: prefix consumed by one other instruction
        offer(2'd1, 1'b0, 1'b0, 1'b0, 16'h00AA, 32'h200);
        adv();
        offer(2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 32'h204);
        adv();
        offer(2'd2, 1'b0, 1'b1, 1'b0, 16'h8000, 32'h208);
        mid();
        check("R4 prefix expired after one instruction", redirect_pc, 32'hFFFF_8000);
        adv();
        quiet();
        finish_branch(1'b0, "pfx expire");

        // R4: reset clears pending prefix
        offer(2'd1, 1'b0, 1'b0, 1'b0, 16'h00BB, 32'h300);
        adv();
        quiet();
        rst_n = 1'b0;
        adv();
        rst_n = 1'b1;
        offer(2'd2, 1'b0, 1'b1, 1'b1, 16'h0001, 32'h304);
        mid();
        check("R4 prefix cleared by reset", redirect_pc, 32'h0000_0001);
        adv();
        quiet();
        finish_branch(1'b1, "pfx reset");

        // R7: user-vector special target, MMU on and off
        msr_um = 1'b1; msr_vm = 1'b0;
        offer(2'd2, 1'b1, 1'b1, 1'b1, 16'h0008, 32'h500);
        mid();
        check("R7 msr_we with MMU", 32'(msr_we), 32'd1);
        check("R7 mode bits cleared", 32'({msr_um_next, msr_vm_next}), 32'd0);
        check("R7 mode bits saved", 32'({msr_ums_next, msr_vms_next}), 32'b10);
        check("R7 no update without MMU", 32'({n_we, n_um}), 32'b01);
        adv();
        quiet();
        finish_branch(1'b1, "uvec");
        offer(2'd2, 1'b1, 1'b1, 1'b1, 16'h0010, 32'h500);
        mid();
        check("R7 other target no update", 32'({msr_we, msr_um_next}), 32'b01);
        adv();
        quiet();
        finish_branch(1'b1, "uvec miss");
        msr_um = 1'b0;

        // R8: branch then prefix in slot are illegal and have no effect
        offer(2'd2, 1'b0, 1'b0, 1'b1, 16'h0020, 32'h600);
        adv();
        offer(2'd2, 1'b0, 1'b1, 1'b0, 16'h0040, 32'h604);
        mid();
        check("R8 branch in slot flagged", 32'(illegal_slot), 32'd1);
        check("R8 slot branch not executed", 32'(redirect_valid), 32'd0);
        adv();
        quiet();
        mid();
        check("R8 idle after bad slot", 32'({slot_active, stall}), 32'd0);
        adv();
        offer(2'd2, 1'b0, 1'b0, 1'b1, 16'h0020, 32'h700);
        adv();
        offer(2'd1, 1'b0, 1'b0, 1'b0, 16'h7777, 32'h704);
        mid();
        check("R8 prefix in slot flagged", 32'(illegal_slot), 32'd1);
        adv();
        offer(2'd2, 1'b0, 1'b1, 1'b0, 16'h0040, 32'h708);
        mid();
        check("R8 slot prefix not latched", redirect_pc, 32'h0000_0040);
        adv();
        quiet();
        finish_branch(1'b0, "after slot pfx");

        // R10: link without delay
        offer(2'd2, 1'b1, 1'b0, 1'b0, 16'h0010, 32'h800);
        mid();
        check("R10 illegal_insn", 32'(illegal_insn), 32'd1);
        check("R10 no redirect or write", 32'({redirect_valid, wb_en}), 32'd0);
        adv();
        quiet();
        mid();
        check("R10 stays idle", 32'({slot_active, stall}), 32'd0);
        adv();

        // R6: instruction offered during flush is ignored
        offer(2'd2, 1'b0, 1'b0, 1'b0, 16'h0010, 32'h900);
        adv();
        offer(2'd2, 1'b1, 1'b1, 1'b1, 16'h0050, 32'h904);
        mid();
        check("R6 ignored during stall", 32'({redirect_valid, wb_en}), 32'd0);
        adv();
        quiet();
        adv();
        mid();
        check("R6 flush ended", 32'(stall), 32'd0);
        adv();

        // R9: requests held across a delayed branch with an empty slot cycle
        irq_req = 1'b1; brk_req = 1'b1;
        mid();
        check("R9 take when idle", 32'({irq_take, brk_take}), 32'b11);
        adv();
        offer(2'd2, 1'b0, 1'b0, 1'b1, 16'h0010, 32'hA00);
        mid();
        check("R9 held in issue cycle", 32'({irq_take, brk_take}), 32'd0);
        adv();
        quiet();
        mid();
        check("R9 held in empty slot", 32'({irq_take, slot_active}), 32'b01);
        adv();
        offer(2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 32'hA04);
        mid();
        check("R9 held while slot completes", 32'({irq_take, brk_take}), 32'd0);
        adv();
        quiet();
        mid();
        check("R9 taken after slot", 32'({irq_take, brk_take}), 32'b11);
        adv();
        offer(2'd2, 1'b0, 1'b0, 1'b0, 16'h0010, 32'hB00);
        adv();
        quiet();
        mid();
        check("R9 held during flush", 32'(irq_take), 32'd0);
        adv();
        adv();
        mid();
        check("R9 taken after flush", 32'(irq_take), 32'd1);
        irq_req = 1'b0; brk_req = 1'b0;
        adv();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule